// File: doc/BRIEF.md
# Variable pulse width symbol receiver

This block turns the digital level of a single-wire variable pulse width bus into decoded symbols and bytes. The input is synchronised and then cleaned by a 3-bit saturating filter clocked at a prescaled time base. After filtering, the width of every active (high) and passive (low) phase is measured in time-base ticks. Each width is classified as a data bit, a start-of-frame, an end-of-data, an idle bus or noise.

Decoded data bits are shifted into a byte register, most significant bit first. Once eight bits have arrived, the block pushes the byte to the host side with a one-cycle strobe. The host does not have to ask for it. The decoder does not care which node drove the bus. While the local node transmits, the echoed byte comes out of this path, and the host compares it with the byte it sent.

One tick normally lasts one microsecond. A four-times-rate mode shortens the tick to a quarter, so every window scales with it. The block also reports noise, a level that says the bus is idle, and a wake pulse when activity returns to an idle bus.

Top module: `vpw_rx`

## Requirements
- R1: A filtered level change needs 7 consecutive ticks of the new raw level. Raw pulses of 5 ticks or fewer produce no symbol, no noise and no wake. A pulse of 10 ticks is seen as a level change.
- R2: With `fast_mode` at 0 a tick lasts `CLKS_PER_US` clocks. With `fast_mode` at 1 it lasts `CLKS_PER_US/4` clocks. All width windows are counted in ticks in both modes.
- R3: When an active phase ends, its width decides the result. 34..95 ticks gives data 1. 96..164 ticks gives data 0. 165..239 ticks gives start-of-frame. Any other width is noise. A start-of-frame (`sym_code` 2) is reported whether or not a frame is open, and it opens a frame with an empty bit count.
- R4: When a passive phase ends, its width decides the result. 34..95 ticks gives data 0 and 96..164 ticks gives data 1. Fewer than 34 ticks is noise. Once a passive phase inside a frame has lasted 165 ticks, end-of-data (`sym_code` 3) is reported and the frame closes.
- R5: Data symbols are reported as `sym_code` 0 or 1. They go into the byte MSB first. On the eighth bit, `byte_valid` pulses for one cycle with the assembled byte on `byte_data`, in the same cycle as that bit's `sym_valid`.
- R6: Outside an open frame, data-width phases produce no symbol and no byte.
- R7: Noise pulses `noise` for one cycle, closes the frame and discards the partial byte. A following frame decodes from a fresh bit count.
- R8: `bus_idle` rises once the filtered bus has been passive for 240 ticks. It falls at the next filtered rising edge.
- R9: A filtered rising edge while `bus_idle` is high pulses `wake` for one cycle.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_mode | input | 1 | Selects the four-times tick rate |
| bus_in | input | 1 | Raw bus level, 1 = active |
| sym_valid | output | 1 | One-cycle strobe for a decoded symbol |
| sym_code | output | 2 | 0 data 0, 1 data 1, 2 start-of-frame, 3 end-of-data |
| byte_valid | output | 1 | One-cycle strobe, byte complete |
| byte_data | output | 8 | Assembled byte |
| noise | output | 1 | One-cycle strobe for an out-of-window phase |
| bus_idle | output | 1 | Bus passive for the idle time |
| wake | output | 1 | One-cycle strobe when an idle bus becomes active |

## Verification
A wrong filter count or tick rate shifts every measured width. That shows up within one symbol as the wrong data value, a spurious noise strobe, or a glitch that wakes the bus. A bad bit counter or shift direction stays hidden until a byte strobe, and it then shows as a wrong byte or a strobe eight bits off. A frame flag left open or closed in error shows up at the next data-width phase as an unexpected or missing symbol. The end-of-data and idle timers show up 165 and 240 ticks into a passive phase.

// File: rtl/vpw_rx.sv
module vpw_rx #(
  parameter int CLKS_PER_US = 16,
  parameter int MIN_T       = 34,
  parameter int SHORT_MAX   = 95,
  parameter int LONG_MAX    = 164,
  parameter int SOF_MAX     = 239,
  parameter int IDLE_T      = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       bus_in,
  output logic       sym_valid,
  output logic [1:0] sym_code,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       noise,
  output logic       bus_idle,
  output logic       wake
);
  localparam int FAST_DIV = (CLKS_PER_US / 4 > 0) ? CLKS_PER_US / 4 : 1;
  localparam int DIV_W    = $clog2(CLKS_PER_US + 1);
  localparam int CNT_W    = $clog2(IDLE_T + 2);
  localparam int EOD_T    = LONG_MAX + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] pre;
  logic [DIV_W-1:0] pre_max;
  logic             tick;
  logic [1:0]       sync;
  logic             raw;
  logic [2:0]       fc;
  logic             filt;
  logic             rise, fall, edge_t;
  logic [CNT_W-1:0] cnt;
  logic             in_frame;
  logic [2:0]       bitcnt;
  logic [6:0]       shreg;

  assign pre_max = fast_mode ? DIV_W'(FAST_DIV - 1) : DIV_W'(CLKS_PER_US - 1);
  assign tick    = (pre >= pre_max);
  assign raw     = sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], bus_in};

  assign rise   = tick &&  raw && (fc == 3'd6) && !filt;
  assign fall   = tick && !raw && (fc == 3'd1) &&  filt;
  assign edge_t = rise || fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fc   <= '0;
      filt <= 1'b0;
    end else if (tick) begin
      if (raw && fc != 3'd7)       fc <= fc + 3'd1;
      else if (!raw && fc != 3'd0) fc <= fc - 3'd1;
      if (rise) filt <= 1'b1;
      if (fall) filt <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cnt <= '0;
    else if (edge_t)                 cnt <= CNT_W'(1);
    else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;

  logic w_short, w_long, w_sof, w_tiny;
  assign w_tiny  = cnt < CNT_W'(MIN_T);
  assign w_short = !w_tiny && cnt <= CNT_W'(SHORT_MAX);
  assign w_long  = cnt > CNT_W'(SHORT_MAX) && cnt <= CNT_W'(LONG_MAX);
  assign w_sof   = cnt > CNT_W'(LONG_MAX) && cnt <= CNT_W'(SOF_MAX);

  logic is_data, data_bit, is_sof, is_noise, is_eod, hit_idle;
  assign is_data  = in_frame && ((fall || rise) && (w_short || w_long));
  assign data_bit = fall ? w_short : w_long;
  assign is_sof   = fall && w_sof;
  assign is_noise = (fall && !(w_short || w_long || w_sof)) || (rise && w_tiny);
  assign is_eod   = in_frame && tick && !filt && !edge_t && cnt == CNT_W'(EOD_T - 1);
  assign hit_idle = tick && !filt && !edge_t && cnt == CNT_W'(IDLE_T - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sym_valid  <= 1'b0;
      sym_code   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      noise      <= 1'b0;
      bus_idle   <= 1'b0;
      wake       <= 1'b0;
      in_frame   <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
    end else begin
      sym_valid  <= is_data || is_sof || is_eod;
      byte_valid <= 1'b0;
      noise      <= is_noise;
      wake       <= rise && bus_idle;
      if (rise)          bus_idle <= 1'b0;
      else if (hit_idle) bus_idle <= 1'b1;
      if (is_sof) begin
        sym_code <= 2'd2;
        in_frame <= 1'b1;
        bitcnt   <= '0;
      end else if (is_eod) begin
        sym_code <= 2'd3;
        in_frame <= 1'b0;
        bitcnt   <= '0;
      end else if (is_noise) begin
        in_frame <= 1'b0;
        bitcnt   <= '0;
      end else if (is_data) begin
        sym_code <= {1'b0, data_bit};
        bitcnt   <= bitcnt + 3'd1;
        shreg    <= {shreg[5:0], data_bit};
        if (bitcnt == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= {shreg, data_bit};
        end
      end
    end

  p_filt_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt));
  p_eod_passive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == 2'd3) |-> !filt);
  p_byte_with_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (sym_valid && !sym_code[1]));
  p_noise_no_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
    noise |-> !sym_valid);
  p_idle_passive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !filt);
  p_wake_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (filt && !bus_idle));
endmodule

// File: tb/tb_vpw_rx.sv
module tb_vpw_rx;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_mode = 1'b0;
  logic       bus_in = 1'b0;
  logic       sym_valid, byte_valid, noise, bus_idle, wake;
  logic [1:0] sym_code;
  logic [7:0] byte_data;

  int checks = 0, errors = 0;
  int noise_seen = 0, wake_seen = 0, exp_noise = 0, exp_wake = 0;
  int sym_q[$];
  int byte_q[$];

  always #2 clk = ~clk;

  vpw_rx #(.CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .bus_in(bus_in),
    .sym_valid(sym_valid), .sym_code(sym_code), .byte_valid(byte_valid),
    .byte_data(byte_data), .noise(noise), .bus_idle(bus_idle), .wake(wake));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int ticks);
    bus_in = lvl;
    repeat (ticks * (fast_mode ? CPU / 4 : CPU)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1, input int nbytes);
    logic [7:0] bytes [2];
    bytes[0] = b0;
    bytes[1] = b1;
    exp_wake++;
    drive(1'b1, 200);
    sym_q.push_back(2);
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 7; k >= 0; k--) begin
        logic v;
        logic act;
        v   = bytes[i][k];
        act = k[0] == 1'b0;
        if (act) drive(1'b1, v ? 64 : 128);
        else     drive(1'b0, v ? 128 : 64);
        sym_q.push_back(int'(v));
      end
      byte_q.push_back(int'(bytes[i]));
    end
    sym_q.push_back(3);
    drive(1'b0, 300);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid) begin
        if (sym_q.size() == 0) check(1'b0, "R3,R4,R6 unexpected symbol", sym_code, -1);
        else begin
          int e;
          e = sym_q.pop_front();
          check(sym_code == e, "R3,R4 symbol code", sym_code, e);
        end
      end
      if (byte_valid) begin
        if (byte_q.size() == 0) check(1'b0, "R5,R6 unexpected byte", byte_data, -1);
        else begin
          int e;
          e = byte_q.pop_front();
          check(byte_data == e, "R5 byte value", byte_data, e);
        end
      end
      if (noise) noise_seen++;
      if (wake) wake_seen++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({sym_valid, sym_code, byte_valid, byte_data, noise, bus_idle, wake} == '0,
          "R10 reset outputs", {byte_data, bus_idle}, 0);

    drive(1'b0, 200);
    check(bus_idle == 1'b0, "R8 not idle at 200 ticks", bus_idle, 0);
    drive(1'b0, 60);
    check(bus_idle == 1'b1, "R8 idle after 240 ticks", bus_idle, 1);

    send_frame(8'hA5, 8'h3C, 2);
    check(sym_q.size() == 0 && byte_q.size() == 0, "R3,R4,R5 frame drained", sym_q.size(), 0);
    check(bus_idle == 1'b1, "R8 idle after frame", bus_idle, 1);
    check(wake_seen == exp_wake, "R9 wake on frame start", wake_seen, exp_wake);

    drive(1'b1, 5);
    drive(1'b0, 300);
    check(noise_seen == exp_noise, "R1 short glitch gives no noise", noise_seen, exp_noise);
    check(wake_seen == exp_wake, "R1 short glitch gives no wake", wake_seen, exp_wake);
    check(bus_idle == 1'b1, "R1 bus stays idle", bus_idle, 1);

    drive(1'b1, 10);
    exp_noise++;
    exp_wake++;
    drive(1'b0, 300);
    check(noise_seen == exp_noise, "R1 R7 ten-tick pulse is noise", noise_seen, exp_noise);
    check(wake_seen == exp_wake, "R9 ten-tick pulse wakes", wake_seen, exp_wake);

    exp_wake++;
    drive(1'b1, 64);
    drive(1'b0, 64);
    drive(1'b1, 128);
    drive(1'b0, 300);
    check(sym_q.size() == 0 && byte_q.size() == 0, "R6 no data outside frame", sym_q.size(), 0);
    check(noise_seen == exp_noise, "R6 no noise outside frame", noise_seen, exp_noise);

    exp_wake++;
    drive(1'b1, 200);
    sym_q.push_back(2);
    drive(1'b0, 64);  sym_q.push_back(0);
    drive(1'b1, 64);  sym_q.push_back(1);
    drive(1'b0, 128); sym_q.push_back(1);
    drive(1'b1, 20);
    exp_noise++;
    drive(1'b0, 300);
    check(noise_seen == exp_noise, "R7 mid-frame noise", noise_seen, exp_noise);
    send_frame(8'h5A, 8'h00, 1);
    check(sym_q.size() == 0 && byte_q.size() == 0, "R7 fresh byte after noise", byte_q.size(), 0);

    exp_wake++;
    drive(1'b1, 300);
    exp_noise++;
    drive(1'b0, 300);
    check(noise_seen == exp_noise, "R3 over-long active is noise", noise_seen, exp_noise);

    fast_mode = 1'b1;
    drive(1'b0, 300);
    send_frame(8'hC3, 8'h81, 2);
    check(sym_q.size() == 0 && byte_q.size() == 0, "R2 fast-mode frame", sym_q.size(), 0);
    check(wake_seen == exp_wake, "R2 R9 wake count", wake_seen, exp_wake);
    check(noise_seen == exp_noise, "R2 no noise in fast mode", noise_seen, exp_noise);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule